// File: doc/BRIEF.md
# Pipelined ADC Digital Correction

This block sits behind a fifteen-stage pipelined converter core in which every stage resolves one decision bit per sample. A stage can only decide after the stage before it has passed on its residue, so the decisions of one sample reach the block over fifteen consecutive clocks, one stage per clock. The block delays each stage's bit so that all fifteen bits of a sample line up. It then adds a calibrated weight for every bit that is set, plus a constant offset term. The sum is rounded and clamped to a 12-bit output code. A new code can be produced on every clock.

The weights come from a sixteen-entry coefficient store with a synchronous write port. Entries 0 to 14 hold the weights of stages 0 to 14, and entry 15 holds the offset. All entries are unsigned and counted in sixteenths of an output LSB. A calibration handshake guards the output. Reset or a request pulse puts the block in a calibrating state and throws away every result still in flight. The block returns to normal operation only when a load-done strobe confirms that the coefficients are in place. Once the pipeline has refilled, valid codes come back.

Top module: `adc_dig_correct`

## Requirements
- R1: While reset is asserted and right after it, `cal_busy` is 1 and `code_valid` is 0.
- R2: Bit k of `stage_bits` belongs to the sample whose stage-0 bit was presented k clocks earlier. The block combines the fifteen bits of each sample correctly however the bit patterns of neighbouring samples differ.
- R3: For each sample, S = entry 15 plus the sum of entry k over every set bit k. The code is (S + 8) >> 4.
- R4: When (S + 8) >> 4 exceeds 4095, the code is 4095.
- R5: When the stage-0 bit of a valid sample is sampled at clock edge E, its code is present with `code_valid` = 1 after edge E+17. A new code follows on every later clock.
- R6: A write sets entry `coef_addr` to `coef_wdata` at the edge where `coef_we` is sampled high. The new value applies to every sample whose stage-0 bit is sampled at that edge minus 14 or later, and to no earlier sample.
- R7: A `cal_req` sampled at edge R gives `cal_busy` = 1 and `code_valid` = 0 after edge R. No sample whose stage-0 bit was sampled at edge R or earlier ever produces a valid code.
- R8: `cal_busy` falls only at an edge where `load_done` = 1 and `cal_req` = 0. If both are high together, the request wins and the block stays busy.
- R9: When `load_done` clears the busy state at edge L, the first valid code appears after edge L+18.
- R10: Rounding is half-up at the 1/16 LSB level. For example, S = 7 gives code 0 and S = 8 gives code 1; S = 23 gives code 1 and S = 24 gives code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stage_bits | input | 15 | Current decision bit of each stage; bit k comes from stage k |
| cal_req | input | 1 | Request for a new calibration; enters the busy state |
| load_done | input | 1 | Strobe confirming that the coefficients are loaded |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | 4 | Coefficient entry: 0-14 stage weights, 15 offset |
| coef_wdata | input | 16 | Unsigned coefficient value in 1/16 LSB units |
| code_out | output | 12 | Corrected output code |
| code_valid | output | 1 | `code_out` holds a valid sample |
| cal_busy | output | 1 | Calibration in progress; output suppressed |

## Verification
The code for a sample is due 17 clock edges after the edge that samples its stage-0 bit. The bench records that edge number with every sample it launches. The scoreboard computes the expected code at edge E+14, the last point where a coefficient write can still affect the sample, and the monitor compares it on the falling edge after edge E+17. A code that arrives on any other cycle is reported as a timing failure. The control checks sample the falling edge after the request or strobe edge for the busy and valid changes, and count edges from load-done to the first valid code, which is due at L+18.

// File: rtl/adc_corr_pkg.sv
`timescale 1ns/1ps
package adc_corr_pkg;
   // Register stages between the aligned bit word and the output code
   localparam int ADD_PIPE = 3;

   typedef enum logic {
      CAL_WAIT = 1'b0,
      CAL_RUN  = 1'b1
   } cal_state_e;
endpackage

// File: rtl/adc_corr_deskew.sv
`timescale 1ns/1ps
module adc_corr_deskew #(
   parameter int N_STAGES = 15
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_STAGES-1:0] raw,
   output logic [N_STAGES-1:0] aligned
);
   // Stage k gets N_STAGES-k registers, so every bit of one sample
   // leaves its chain at the same edge.
   for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
      localparam int DEPTH = N_STAGES - k;
      if (DEPTH == 1) begin : g_one
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= raw[k];
         end
         assign aligned[k] = q;
      end else begin : g_chain
         logic [DEPTH-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '0;
            else        sr <= {sr[DEPTH-2:0], raw[k]};
         end
         assign aligned[k] = sr[DEPTH-1];
      end
   end
endmodule

// File: rtl/adc_corr_coef_ram.sv
`timescale 1ns/1ps
module adc_corr_coef_ram #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 16,
   parameter int AW    = 4
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we,
   input  logic [AW-1:0]               addr,
   input  logic [WIDTH-1:0]            wdata,
   output logic [DEPTH-1:0][WIDTH-1:0] rd_all
);
   logic [DEPTH-1:0][WIDTH-1:0] mem;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem <= '0;
      end else if (we && (32'(addr) < DEPTH)) begin
         mem[addr] <= wdata;
      end
   end

   assign rd_all = mem;

   // R6: a write is visible on the read side right after its edge
   assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (32'(addr) < DEPTH)) |=> (rd_all[$past(addr)] == $past(wdata)));
endmodule

// File: rtl/adc_corr_sum.sv
`timescale 1ns/1ps
module adc_corr_sum #(
   parameter int N_STAGES = 15,
   parameter int COEF_W   = 16,
   parameter int OUT_W    = 12,
   parameter int FRAC_W   = 4,
   parameter int GRP_SZ   = 4
)(
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [N_STAGES-1:0]            bits_al,
   input  logic [N_STAGES:0][COEF_W-1:0]  coefs,
   output logic [OUT_W-1:0]               code
);
   localparam int N_TERMS = N_STAGES + 1;
   localparam int N_GRP   = N_TERMS / GRP_SZ;
   localparam int PART_W  = COEF_W + $clog2(GRP_SZ);
   localparam int SUM_W   = COEF_W + $clog2(N_TERMS);
   localparam int RND_W   = SUM_W + 1;
   localparam int HALF    = 1 << (FRAC_W - 1);

   // The offset entry is always included in the sum
   logic [N_TERMS-1:0] use_term;
   assign use_term = {1'b1, bits_al};

   // Pipeline stage 1: partial sums over groups of terms
   logic [N_GRP-1:0][PART_W-1:0] part_d, part_q;
   always_comb begin
      for (int g = 0; g < N_GRP; g++) begin
         part_d[g] = '0;
         for (int j = 0; j < GRP_SZ; j++) begin
            if (use_term[g*GRP_SZ + j])
               part_d[g] = part_d[g] + PART_W'(coefs[g*GRP_SZ + j]);
         end
      end
   end

   // Pipeline stage 2: total over the groups
   logic [SUM_W-1:0] total_d, total_q;
   always_comb begin
      total_d = '0;
      for (int g = 0; g < N_GRP; g++) total_d = total_d + SUM_W'(part_q[g]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         part_q  <= '0;
         total_q <= '0;
      end else begin
         part_q  <= part_d;
         total_q <= total_d;
      end
   end

   // Pipeline stage 3: round half-up, then clamp when the range can overflow
   logic [RND_W-1:0] rnd;
   logic [OUT_W-1:0] code_d;
   assign rnd = ({1'b0, total_q} + RND_W'(HALF)) >> FRAC_W;

   if (RND_W - FRAC_W > OUT_W) begin : g_clamp
      localparam logic [RND_W-1:0] MAXV = RND_W'((1 << OUT_W) - 1);
      localparam int CLAMP_AT = ((1 << OUT_W) << FRAC_W) - HALF;
      assign code_d = (rnd > MAXV) ? OUT_W'(MAXV) : rnd[OUT_W-1:0];

      // R4: a total that rounds above full scale yields full scale
      assert_clamp_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (32'(total_q) >= CLAMP_AT) |=> (code == OUT_W'((1 << OUT_W) - 1)));
   end else begin : g_noclamp
      assign code_d = OUT_W'(rnd);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code <= '0;
      else        code <= code_d;
   end
endmodule

// File: rtl/adc_corr_ctrl.sv
`timescale 1ns/1ps
module adc_corr_ctrl #(
   parameter int LAT = 17
)(
   input  logic clk,
   input  logic rst_n,
   input  logic cal_req,
   input  logic load_done,
   output logic cal_busy,
   output logic code_valid
);
   import adc_corr_pkg::*;

   cal_state_e st;
   logic [LAT:0] vpipe;

   // The request has priority over the done strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         st <= CAL_WAIT;
      else if (cal_req)   st <= CAL_WAIT;
      else if (load_done) st <= CAL_RUN;
   end

   // Launch marks follow each sample; a request discards all of them
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       vpipe <= '0;
      else if (cal_req) vpipe <= '0;
      else              vpipe <= {vpipe[LAT-1:0], st == CAL_RUN};
   end

   assign cal_busy   = (st == CAL_WAIT);
   assign code_valid = vpipe[LAT];

   // R7: a request enters the busy state and suppresses output at once
   assert_req_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cal_req |=> (cal_busy && !code_valid));

   // R7: no valid code while calibrating
   assert_busy_no_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cal_busy |-> !code_valid);

   // R8: only the done strobe releases the busy state
   assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_busy && !load_done) |=> cal_busy);

   // R5: once flowing, one code per clock until a request
   assert_valid_stream_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (code_valid && !cal_req) |=> code_valid);
endmodule

// File: rtl/adc_dig_correct.sv
`timescale 1ns/1ps
module adc_dig_correct #(
   parameter  int N_STAGES = 15,
   parameter  int COEF_W   = 16,
   parameter  int OUT_W    = 12,
   parameter  int FRAC_W   = 4,
   parameter  int GRP_SZ   = 4,
   localparam int ADDR_W   = $clog2(N_STAGES + 1)
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_STAGES-1:0] stage_bits,
   input  logic                cal_req,
   input  logic                load_done,
   input  logic                coef_we,
   input  logic [ADDR_W-1:0]   coef_addr,
   input  logic [COEF_W-1:0]   coef_wdata,
   output logic [OUT_W-1:0]    code_out,
   output logic                code_valid,
   output logic                cal_busy
);
   import adc_corr_pkg::*;

   localparam int N_COEF = N_STAGES + 1;
   localparam int LAT    = (N_STAGES - 1) + ADD_PIPE;

   if (N_STAGES < 2) begin : g_chk_stages
      $error("N_STAGES must be at least 2");
   end
   if (FRAC_W < 1) begin : g_chk_frac
      $error("FRAC_W must be at least 1");
   end
   if (N_COEF % GRP_SZ != 0) begin : g_chk_grp
      $error("GRP_SZ must divide N_STAGES+1");
   end

   logic [N_STAGES-1:0]            aligned;
   logic [N_COEF-1:0][COEF_W-1:0]  coefs;

   adc_corr_deskew #(.N_STAGES(N_STAGES)) u_deskew (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw     (stage_bits),
      .aligned (aligned)
   );

   adc_corr_coef_ram #(.DEPTH(N_COEF), .WIDTH(COEF_W), .AW(ADDR_W)) u_ram (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (coef_we),
      .addr   (coef_addr),
      .wdata  (coef_wdata),
      .rd_all (coefs)
   );

   adc_corr_sum #(
      .N_STAGES (N_STAGES),
      .COEF_W   (COEF_W),
      .OUT_W    (OUT_W),
      .FRAC_W   (FRAC_W),
      .GRP_SZ   (GRP_SZ)
   ) u_sum (
      .clk     (clk),
      .rst_n   (rst_n),
      .bits_al (aligned),
      .coefs   (coefs),
      .code    (code_out)
   );

   adc_corr_ctrl #(.LAT(LAT)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cal_req    (cal_req),
      .load_done  (load_done),
      .cal_busy   (cal_busy),
      .code_valid (code_valid)
   );
endmodule

// File: tb/tb_adc_dig_correct.sv
`timescale 1ns/1ps
module tb_adc_dig_correct;
   localparam int NS = 15, CW = 16, OW = 12, AW = 4, LAT = 17, WD_LIMIT = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] stage_bits = '0;
   logic          cal_req = 1'b0, load_done = 1'b0, coef_we = 1'b0;
   logic [AW-1:0] coef_addr = '0;
   logic [CW-1:0] coef_wdata = '0;
   logic [OW-1:0] code_out;
   logic          code_valid, cal_busy;

   adc_dig_correct dut (
      .clk(clk), .rst_n(rst_n), .stage_bits(stage_bits), .cal_req(cal_req),
      .load_done(load_done), .coef_we(coef_we), .coef_addr(coef_addr),
      .coef_wdata(coef_wdata), .code_out(code_out), .code_valid(code_valid),
      .cal_busy(cal_busy)
   );

   always #2.5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int    errors = 0, checks = 0;
   int    mode = 2;
   bit    mbusy = 1'b1;
   int    kill_e = -1;
   string tag = "R3";
   int    mcoef [NS+1];

   typedef struct { int e; logic [NS-1:0] bits; bit v; } pend_t;
   typedef struct { int e; int t; int code; } exp_t;
   pend_t pend [$];
   exp_t  expq [$];
   logic [NS-1:0] hist [NS];

   function automatic int model(logic [NS-1:0] b);
      int s = mcoef[NS];
      for (int k = 0; k < NS; k++) if (b[k]) s += mcoef[k];
      s = (s + 8) >>> 4;
      if (s > 4095) s = 4095;
      return s;
   endfunction

   task automatic chk(input bit ok, input string t, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", t, act, exp, cyc);
      end
   endtask

   // Driver: one new sample per clock, bits staggered by stage
   initial begin
      for (int k = 0; k < NS; k++) hist[k] = '0;
      forever begin
         logic [NS-1:0] nb;
         int e;
         @(negedge clk);
         e = cyc + 1;
         case (mode)
            0:       nb = '0;
            1:       nb = '1;
            3:       nb = NS'(1) << (e % NS);
            4:       nb = (e % 2 == 0) ? NS'(15'h5555) : NS'(15'h2AAA);
            default: nb = NS'($urandom);
         endcase
         for (int k = NS - 1; k > 0; k--) hist[k] = hist[k-1];
         hist[0] = nb;
         for (int k = 0; k < NS; k++) stage_bits[k] = hist[k][k];
         pend.push_back('{e: e, bits: nb, v: !mbusy});
      end
   end

   // Scoreboard: expected code fixed at edge E+14 (last edge a write may affect it)
   initial forever begin
      @(negedge clk);
      while (pend.size() > 0 && pend[0].e + 14 <= cyc) begin
         pend_t p;
         p = pend.pop_front();
         if (p.v && p.e > kill_e) expq.push_back('{e: p.e, t: p.e + LAT, code: model(p.bits)});
      end
   end

   // Monitor: result due after edge E+17
   initial forever begin
      @(negedge clk);
      while (expq.size() > 0 && expq[0].e <= kill_e) void'(expq.pop_front());
      if (expq.size() > 0 && expq[0].t == cyc) begin
         exp_t x;
         x = expq.pop_front();
         if (!code_valid) chk(1'b0, "R5 valid due", 0, 1);
         else             chk(32'(code_out) == x.code, tag, 32'(code_out), x.code);
      end else if (code_valid) begin
         chk(1'b0, "R5 unexpected valid", 1, 0);
      end
   end

   // Watchdog
   initial begin
      wait (cyc > WD_LIMIT);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WD_LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      coef_we = 1'b1; coef_addr = AW'(a); coef_wdata = CW'(d);
      @(posedge clk);
      mcoef[a] = d;
      @(negedge clk);
      coef_we = 1'b0;
   endtask

   task automatic load_set(input int top, input int off);
      for (int k = 0; k < NS; k++) wr(k, top >> k);
      wr(NS, off);
   endtask

   task automatic done_pulse(output int l);
      @(negedge clk);
      load_done = 1'b1;
      l = cyc + 1;
      @(posedge clk);
      mbusy = 1'b0;
      @(negedge clk);
      load_done = 1'b0;
   endtask

   task automatic req_pulse(input bit with_done);
      int r;
      @(negedge clk);
      cal_req = 1'b1; load_done = with_done;
      r = cyc + 1;
      @(posedge clk);
      mbusy = 1'b1;
      kill_e = r;
      @(negedge clk);
      cal_req = 1'b0; load_done = 1'b0;
      chk(cal_busy == 1'b1, with_done ? "R8 request beats done" : "R7 busy after request",
          int'(cal_busy), 1);
      chk(code_valid == 1'b0, "R7 valid dropped", int'(code_valid), 0);
   endtask

   task automatic first_valid(input int l);
      int n = 0;
      while (!code_valid && n < 40) begin @(negedge clk); n++; end
      chk(cyc == l + LAT + 1, "R9 first valid edge", cyc - l, LAT + 1);
   endtask

   initial begin
      int l;
      for (int k = 0; k <= NS; k++) mcoef[k] = 0;
      tick(3);
      chk(cal_busy == 1'b1, "R1 busy in reset", int'(cal_busy), 1);
      chk(code_valid == 1'b0, "R1 valid in reset", int'(code_valid), 0);
      rst_n = 1'b1;
      tick(2);
      chk(cal_busy == 1'b1, "R1 busy after reset", int'(cal_busy), 1);

      load_set(40000, 100);
      chk(cal_busy == 1'b1, "R8 busy until done", int'(cal_busy), 1);

      tag = "R3 random";
      mode = 2;
      done_pulse(l);
      chk(cal_busy == 1'b0, "R8 busy cleared by done", int'(cal_busy), 0);
      first_valid(l);
      tick(60);

      tag = "R2 walking one";
      mode = 3;
      tick(45);
      tag = "R2 alternating";
      mode = 4;
      tick(30);

      tag = "R4 clamp";
      mode = 1;
      tick(30);

      tag = "R3 offset only";
      mode = 0;
      tick(25);

      tag = "R10 rounding";
      wr(NS, 7);  tick(20);
      wr(NS, 8);  tick(20);
      wr(NS, 23); tick(20);
      wr(NS, 24); tick(20);

      tag = "R6 live write";
      mode = 2;
      wr(NS, 100);
      tick(5);
      wr(3, 12345);
      tick(3);
      wr(0, 20000);
      tick(30);

      mode = 2;
      req_pulse(1'b0);
      tick(25);
      chk(cal_busy == 1'b1, "R7 still busy", int'(cal_busy), 1);
      chk(code_valid == 1'b0, "R7 still suppressed", int'(code_valid), 0);

      load_set(30000, 50);
      tag = "R3 second set";
      done_pulse(l);
      first_valid(l);
      tick(20);
      req_pulse(1'b1);
      tick(5);
      chk(cal_busy == 1'b1, "R8 request beats done hold", int'(cal_busy), 1);
      done_pulse(l);
      first_valid(l);
      tag = "R2 second set walking";
      mode = 3;
      tick(40);
      tag = "R3 second set random";
      mode = 2;
      tick(40);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule